// File: doc/BRIEF.md
# BCD Time and Calendar Counter with Alarm Comparator

This block keeps wall-clock time and the calendar date in packed BCD. It advances by one second on every qualified one-second tick and carries through minutes, hours, day of week, day of month, month and a two-digit year. Month lengths and the February leap day are handled internally, so the host only has to load a valid starting point. The hours byte carries its own format flag, so one register selects either a 24-hour count or a 12-hour count with a PM flag.

Three alarm registers hold a target second, minute and hour. A comparator raises a level output while the live time equals the alarm time. A simple register-style write port and a registered read port let a host interface, built elsewhere, load and inspect every counter. A run input gates the tick, so a stopped clock holds its time while it is being set.

Top module: `tcal_core`

## Requirements
- R1: After synchronous reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), day of week 01, date 01, month 01, year 00, and all alarm registers 00.
- R2: Seconds and minutes count 00 to 59 in packed BCD; a tick at second 59 returns seconds to 00 and advances minutes, and minute 59 with second 59 returns minutes to 00 and advances hours.
- R3: With hours bit 7 = 0 (24-hour form) hours count 00 to 23; leaving 23:59:59 gives 00:00:00 and advances the date and day of week.
- R4: With hours bit 7 = 1 (12-hour form) bits 4:0 hold 01 to 12 in BCD and bit 5 is the PM flag; hour 11 steps to 12 and inverts bit 5, hour 12 steps to 01 with bit 5 unchanged, and the date advances only on the PM 11 to AM 12 step (B1 hex to 92 hex).
- R5: Day of week counts 1 to 7 and wraps from 7 to 1 when the date advances.
- R6: The date wraps to 01 and the month advances after day 30 in April, June, September and November and after day 31 in the other months except February.
- R7: In February the last day is 29 when the BCD year value is divisible by 4 and 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R9: While run is low, ticks have no effect and every time and calendar register keeps its value.
- R10: A host write loads its register in the same clock edge and wins over a tick in that cycle; the other registers still advance as that tick dictates from their prior values.
- R11: alarm_match is high one cycle after alarm seconds, minutes and hours bits 5:0 equal the live seconds, minutes and hours bits 5:0; alarm hours bits 7:6 are ignored, so the PM flag takes part in the compare.
- R12: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 alarm seconds, 9 alarm minutes, 10 alarm hours; rd_data shows the addressed register one clock after rd_addr, unused addresses read 00, hours bit 6 and alarm hours bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one clock wide |
| run | input | 1 | High lets ticks advance the counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write register address |
| wr_data | input | 8 | Write data, packed BCD |
| rd_addr | input | AW | Read register address |
| rd_data | output | 8 | Registered read data |
| alarm_match | output | 1 | Registered alarm equality |

## Verification
The chain is driven from time and date preloads that sit one tick before each carry boundary: a plain seconds wrap, the end of a 31-day and a 30-day month, February in a leap and a non-leap year, the end of the century, and the three distinct 12-hour steps. Each preload tells apart a wrong limit from a wrong carry, since the register at the boundary and the one it feeds are both read. Ticks with run low and writes coinciding with a tick separate gating and priority from the normal advance. The alarm is tried with matching and off-by-one times and with AM against PM, showing that the flag counts while the top two bits do not.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

  localparam int REG_AW = 4;

  localparam logic [3:0] ADR_SEC   = 4'h0;
  localparam logic [3:0] ADR_MIN   = 4'h1;
  localparam logic [3:0] ADR_HOUR  = 4'h2;
  localparam logic [3:0] ADR_DOW   = 4'h3;
  localparam logic [3:0] ADR_DATE  = 4'h4;
  localparam logic [3:0] ADR_MON   = 4'h5;
  localparam logic [3:0] ADR_YEAR  = 4'h6;
  localparam logic [3:0] ADR_ALARM = 4'h8;

  // Next BCD value: wraps from last to first, otherwise adds one.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last)            return first;
    else if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
    else                      return v + 8'd1;
  endfunction

  function automatic logic leap_bcd(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m,
                                            input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tcal_time.sv
module tcal_time
  import tcal_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [6:0]    sec_q,
  output logic [6:0]    min_q,
  output logic [7:0]    hour_q,
  output logic          day_carry
);

  logic [7:0] sec_nx8, min_nx8, hour_nx, h24_nx8, h12_nx8;
  logic       sec_end, min_end, hour_wrap;
  logic       adv_min, adv_hour;
  logic       w_sec, w_min, w_hour;

  assign w_sec  = wr_en && (wr_addr == AW'(ADR_SEC));
  assign w_min  = wr_en && (wr_addr == AW'(ADR_MIN));
  assign w_hour = wr_en && (wr_addr == AW'(ADR_HOUR));

  assign sec_end = (sec_q == 7'h59);
  assign min_end = (min_q == 7'h59);
  assign sec_nx8 = bcd_step({1'b0, sec_q}, 8'h59, 8'h00);
  assign min_nx8 = bcd_step({1'b0, min_q}, 8'h59, 8'h00);
  assign h24_nx8 = bcd_step({2'b00, hour_q[5:0]}, 8'h23, 8'h00);
  assign h12_nx8 = bcd_step({3'b000, hour_q[4:0]}, 8'h12, 8'h01);

  always_comb begin
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {1'b1, 1'b0, ~hour_q[5], 5'h12};
        hour_wrap = hour_q[5];
      end else begin
        hour_nx   = {1'b1, 1'b0, hour_q[5], h12_nx8[4:0]};
        hour_wrap = 1'b0;
      end
    end else begin
      hour_nx   = {2'b00, h24_nx8[5:0]};
      hour_wrap = (hour_q[5:0] == 6'h23);
    end
  end

  assign adv_min   = step && sec_end;
  assign adv_hour  = adv_min && min_end;
  assign day_carry = adv_hour && hour_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hour_q <= 8'h00;
    end else begin
      if (w_sec)         sec_q <= wr_data[6:0];
      else if (step)     sec_q <= sec_nx8[6:0];

      if (w_min)         min_q <= wr_data[6:0];
      else if (adv_min)  min_q <= min_nx8[6:0];

      if (w_hour)        hour_q <= {wr_data[7], 1'b0, wr_data[5:0]};
      else if (adv_hour) hour_q <= hour_nx;
    end
  end

endmodule

// File: rtl/tcal_date.sv
module tcal_date
  import tcal_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_day,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [2:0]    dow_q,
  output logic [5:0]    date_q,
  output logic [4:0]    mon_q,
  output logic [7:0]    year_q
);

  logic [7:0] last_day, date_nx8, mon_nx8, year_nx8;
  logic       date_end, mon_end, adv_mon, adv_year;
  logic       w_dow, w_date, w_mon, w_year;

  assign w_dow  = wr_en && (wr_addr == AW'(ADR_DOW));
  assign w_date = wr_en && (wr_addr == AW'(ADR_DATE));
  assign w_mon  = wr_en && (wr_addr == AW'(ADR_MON));
  assign w_year = wr_en && (wr_addr == AW'(ADR_YEAR));

  assign last_day = month_last({3'b000, mon_q}, leap_bcd(year_q));
  assign date_end = ({2'b00, date_q} == last_day);
  assign mon_end  = (mon_q == 5'h12);
  assign date_nx8 = date_end ? 8'h01 : bcd_step({2'b00, date_q}, 8'hFF, 8'h01);
  assign mon_nx8  = bcd_step({3'b000, mon_q}, 8'h12, 8'h01);
  assign year_nx8 = bcd_step(year_q, 8'h99, 8'h00);

  assign adv_mon  = step_day && date_end;
  assign adv_year = adv_mon && mon_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      dow_q  <= 3'd1;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      year_q <= 8'h00;
    end else begin
      if (w_dow)         dow_q <= wr_data[2:0];
      else if (step_day) dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;

      if (w_date)        date_q <= wr_data[5:0];
      else if (step_day) date_q <= date_nx8[5:0];

      if (w_mon)         mon_q <= wr_data[4:0];
      else if (adv_mon)  mon_q <= mon_nx8[4:0];

      if (w_year)        year_q <= wr_data;
      else if (adv_year) year_q <= year_nx8;
    end
  end

endmodule

// File: rtl/tcal_alarm.sv
module tcal_alarm
  import tcal_pkg::*;
#(
  parameter int AW     = REG_AW,
  parameter int FIELDS = 3,
  parameter int FW     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [FIELDS*FW-1:0] live,
  output logic [FIELDS*FW-1:0] alarm_q,
  output logic                match_q
);

  logic [FIELDS-1:0] eq;

  for (genvar g = 0; g < FIELDS; g++) begin : g_fld
    // the hours field keeps only the BCD digits and the PM flag
    localparam logic [FW-1:0] MASK = (g == FIELDS - 1) ? FW'(7'h3F) : FW'(7'h7F);
    logic [FW-1:0] val_q;
    logic          sel;

    assign sel = wr_en && (wr_addr == AW'(ADR_ALARM) + AW'(g));

    always_ff @(posedge clk) begin
      if (rst)      val_q <= '0;
      else if (sel) val_q <= wr_data[FW-1:0] & MASK;
    end

    assign eq[g] = (val_q == (live[g*FW +: FW] & MASK));
    assign alarm_q[g*FW +: FW] = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= &eq;
  end

endmodule

// File: rtl/tcal_core.sv
module tcal_core
  import tcal_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          alarm_match
);

  localparam int FIELDS = 3;
  localparam int FW     = 7;

  logic [6:0] sec_w, min_w;
  logic [7:0] hour_w, year_w;
  logic [2:0] dow_w;
  logic [5:0] date_w;
  logic [4:0] mon_w;
  logic       day_carry, step;
  logic [FIELDS*FW-1:0] live_w, alarm_w;
  logic [7:0] rd_q;

  assign step = tick && run;

  tcal_time #(.AW(AW)) u_time (
    .clk(clk), .rst(rst), .step(step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_q(sec_w), .min_q(min_w), .hour_q(hour_w), .day_carry(day_carry)
  );

  tcal_date #(.AW(AW)) u_date (
    .clk(clk), .rst(rst), .step_day(day_carry),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dow_q(dow_w), .date_q(date_w), .mon_q(mon_w), .year_q(year_w)
  );

  assign live_w = {1'b0, hour_w[5:0], min_w, sec_w};

  tcal_alarm #(.AW(AW), .FIELDS(FIELDS), .FW(FW)) u_alarm (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live(live_w), .alarm_q(alarm_w), .match_q(alarm_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 8'h00;
    end else begin
      case (rd_addr)
        AW'(ADR_SEC):       rd_q <= {1'b0, sec_w};
        AW'(ADR_MIN):       rd_q <= {1'b0, min_w};
        AW'(ADR_HOUR):      rd_q <= hour_w;
        AW'(ADR_DOW):       rd_q <= {5'b0, dow_w};
        AW'(ADR_DATE):      rd_q <= {2'b0, date_w};
        AW'(ADR_MON):       rd_q <= {3'b0, mon_w};
        AW'(ADR_YEAR):      rd_q <= year_w;
        AW'(ADR_ALARM):     rd_q <= {1'b0, alarm_w[FW-1:0]};
        AW'(ADR_ALARM + 1): rd_q <= {1'b0, alarm_w[2*FW-1:FW]};
        AW'(ADR_ALARM + 2): rd_q <= {1'b0, alarm_w[3*FW-1:2*FW]};
        default:            rd_q <= 8'h00;
      endcase
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tcal_core_chk.sv
module tcal_core_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          run,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [6:0]    sec,
  input logic [6:0]    min,
  input logic [7:0]    hour,
  input logic [2:0]    dow
);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !wr_en && sec == 7'h59) |=> (sec == 7'h00));

  // R9
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow)));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(0)) |=> (sec == $past(wr_data[6:0])));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !wr_en && hour[7] && hour[4:0] == 5'h11 && min == 7'h59 && sec == 7'h59)
      |=> (hour[5] != $past(hour[5])));

  // R5
  dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !wr_en && dow == 3'd7 && hour == 8'h23 && min == 7'h59 && sec == 7'h59)
      |=> (dow == 3'd1));

endmodule

bind tcal_core tcal_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sec(sec_w), .min(min_w), .hour(hour_w), .dow(dow_w)
);

// File: tb/tcal_core_tb.sv
module tcal_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst, tick, run, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  logic          alarm_match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcal_core #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_match(alarm_match)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // write one register, optionally with a tick in the same cycle
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic t = 1'b0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'h2, h); wr(4'h1, m); wr(4'h0, s);
  endtask

  task automatic set_date(input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(4'h3, w); wr(4'h4, d); wr(4'h5, mo); wr(4'h6, y);
  endtask

  task automatic t_reset();
    expect_reg("R1 sec", 4'h0, 8'h00);
    expect_reg("R1 hour", 4'h2, 8'h00);
    expect_reg("R1 dow", 4'h3, 8'h01);
    expect_reg("R1 date", 4'h4, 8'h01);
    expect_reg("R1 month", 4'h5, 8'h01);
    expect_reg("R1 year", 4'h6, 8'h00);
    expect_reg("R1 alarm hour", 4'hA, 8'h00);
  endtask

  task automatic t_seconds();
    set_time(8'h00, 8'h00, 8'h58);
    pulse(1);
    expect_reg("R2 sec 59", 4'h0, 8'h59);
    pulse(1);
    expect_reg("R2 sec wrap", 4'h0, 8'h00);
    expect_reg("R2 min carry", 4'h1, 8'h01);
    set_time(8'h07, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R2 min wrap", 4'h1, 8'h00);
    expect_reg("R2 hour carry", 4'h2, 8'h08);
  endtask

  task automatic t_day24();
    set_date(8'h07, 8'h31, 8'h01, 8'h24);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R3 hour wrap", 4'h2, 8'h00);
    expect_reg("R5 dow wrap", 4'h3, 8'h01);
    expect_reg("R6 jan31 date", 4'h4, 8'h01);
    expect_reg("R6 jan31 month", 4'h5, 8'h02);
  endtask

  task automatic t_feb();
    set_date(8'h02, 8'h28, 8'h02, 8'h24);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R7 leap 29", 4'h4, 8'h29);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R7 leap end date", 4'h4, 8'h01);
    expect_reg("R7 leap end month", 4'h5, 8'h03);
    set_date(8'h02, 8'h28, 8'h02, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R7 common date", 4'h4, 8'h01);
    expect_reg("R7 common month", 4'h5, 8'h03);
  endtask

  task automatic t_thirty();
    set_date(8'h03, 8'h30, 8'h04, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R6 apr30 date", 4'h4, 8'h01);
    expect_reg("R6 apr30 month", 4'h5, 8'h05);
    set_date(8'h03, 8'h30, 8'h05, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R6 may30 date", 4'h4, 8'h31);
  endtask

  task automatic t_century();
    set_date(8'h05, 8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R8 month wrap", 4'h5, 8'h01);
    expect_reg("R8 year wrap", 4'h6, 8'h00);
    set_date(8'h05, 8'h31, 8'h12, 8'h19);
    set_time(8'h23, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R8 year digit", 4'h6, 8'h20);
  endtask

  task automatic t_twelve();
    set_date(8'h02, 8'h10, 8'h01, 8'h30);
    set_time(8'h91, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R4 am11 to pm12", 4'h2, 8'hB2);
    expect_reg("R4 no date at noon", 4'h4, 8'h10);
    set_time(8'hB2, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R4 pm12 to pm01", 4'h2, 8'hA1);
    set_time(8'hB1, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R4 pm11 to am12", 4'h2, 8'h92);
    expect_reg("R4 date at midnight", 4'h4, 8'h11);
    set_time(8'h92, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R4 am12 to am01", 4'h2, 8'h81);
    set_time(8'h89, 8'h59, 8'h59);
    pulse(1);
    expect_reg("R4 am09 to am10", 4'h2, 8'h90);
  endtask

  task automatic t_run();
    set_time(8'h10, 8'h59, 8'h59);
    run = 1'b0;
    pulse(3);
    expect_reg("R9 sec held", 4'h0, 8'h59);
    expect_reg("R9 hour held", 4'h2, 8'h10);
    run = 1'b1;
    pulse(1);
    expect_reg("R9 resumes", 4'h2, 8'h11);
  endtask

  task automatic t_prio();
    set_time(8'h04, 8'h10, 8'h20);
    wr(4'h0, 8'h30, 1'b1);
    expect_reg("R10 write beats tick", 4'h0, 8'h30);
    set_time(8'h04, 8'h10, 8'h59);
    wr(4'h1, 8'h05, 1'b1);
    expect_reg("R10 written min", 4'h1, 8'h05);
    expect_reg("R10 sec still steps", 4'h0, 8'h00);
  endtask

  task automatic t_alarm();
    wr(4'h8, 8'h30); wr(4'h9, 8'h15); wr(4'hA, 8'hC5);
    set_time(8'h05, 8'h15, 8'h29);
    pulse(1);
    expect_reg("R12 alarm hour top bits", 4'hA, 8'h05);
    chk("R11 match", {7'b0, alarm_match}, 8'h01);
    pulse(1);
    @(negedge clk);
    chk("R11 no match after", {7'b0, alarm_match}, 8'h00);
    wr(4'hA, 8'h25);
    set_time(8'h85, 8'h15, 8'h30);
    @(negedge clk);
    chk("R11 am vs pm", {7'b0, alarm_match}, 8'h00);
    wr(4'h2, 8'hA5);
    @(negedge clk);
    chk("R11 pm match", {7'b0, alarm_match}, 8'h01);
  endtask

  task automatic t_read();
    expect_reg("R12 unused addr", 4'h7, 8'h00);
    wr(4'h2, 8'hD2);
    expect_reg("R12 hour bit6", 4'h2, 8'h92);
    wr(4'hF, 8'h55);
    expect_reg("R12 unused write", 4'hF, 8'h00);
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; run = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_day24();
    t_feb();
    t_thirty();
    t_century();
    t_twelve();
    t_run();
    t_prio();
    t_alarm();
    t_read();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule